// File: doc/BRIEF.md
# Counted-Burst SPI Master with Byte FIFOs

This block is a register-mapped SPI master. Software pushes bytes into a transmit queue. It programs how many bytes the burst lasts and how many of those come from the queue, then sets a start bit. The engine shifts the burst out on MOSI, most significant bit first, and stores one received byte per burst byte in a receive queue. When the last byte is done it drops the start bit, so software can poll that bit to see when the burst has ended.

Serial timing is paced by an external bit-clock enable. Each pulse advances SCK by half a period. Clock polarity and phase follow the usual four SPI modes. One of four select lines is chosen by a two-bit field. The selected line either follows a software level (manual) or is held active for the length of the burst (automatic). Its active polarity is programmable. A status word reports the fill level of both queues.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, the control word (offset 0x08), the status word (offset 0x28) and the burst count (offset 0x20) read 0. SCK is 0 and all four select lines are 0.
- R2: A write to offset 0x04 adds one byte to the 64-entry transmit queue; a write made while 64 bytes are queued is dropped. The status word shows the receive level in bits 6:0 and the transmit level in bits 22:16.
- R3: Writing control bit 8 as 1 empties the transmit queue, and writing control bit 9 as 1 empties the receive queue. Both bits always read back 0.
- R4: Writing control bit 10 as 1 starts a burst only when the same write also sets bit 0 (enable) and bit 1 (master) and the burst count is nonzero. Bit 10 then reads 1 until the last byte finishes and 0 afterwards. In every other case it reads 0.
- R5: SCK idles at control bit 3 (CPOL). With control bit 2 (CPHA) clear, data is sampled on the leading edge and changed on the trailing edge; with it set, the reverse. Bits go out most significant first.
- R6: The burst length is the count at offset 0x20, bits 23:0. Burst byte k comes from the transmit queue when k is below the transmit count (offset 0x24, bits 23:0) and the queue is not empty; otherwise it is 0x00. One received byte is captured for every burst byte.
- R7: A read of offset 0x00 returns the oldest received byte in bits 7:0 and removes it; when the queue is empty the read returns 0. A received byte that finds 64 bytes already queued is dropped.
- R8: Control bits 13:12 choose select line 0 to 3. Control bit 4 set makes the active level 0, and every line that is not active holds the opposite level.
- R9: With control bit 16 clear, the chosen line is active exactly while a burst runs. With bit 16 set, the chosen line takes the level of control bit 17.
- R10: A control write that clears bit 0 during a burst stops it at once: bit 10 reads 0, SCK returns to idle and no further edges occur.
- R11: Each bit-clock enable pulse during a burst makes exactly one SCK edge, and SCK does not change without one, so a burst of n bytes makes 16n edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at offset 0x00) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| bit_tick | input | 1 | Half-bit enable from the divider |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |

## Verification
The bench connects a slave model that works in all four modes. It runs bursts where the transmit count is equal to, shorter than or zero compared with the burst length, and also with a queue that runs dry before the count is reached. A design that kept fetching past the count, or that repeated stale data instead of sending zeros, would show the wrong bytes at the slave. Swapping the sample and launch edges would shift each received byte by one bit, and this shows up in both directions. The bench also overfills both queues, aborts a burst midway, tries starts that must be refused, and drives the select lines in manual and automatic modes. These cases catch an off-by-one in the queue-full test, a start bit that sticks, or a select line left active after an abort.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int FIFO_AW = 6,
  parameter int CNT_W   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        bit_tick,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  cs_line
);
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int PW    = FIFO_AW + 1;
  localparam logic [5:0] A_RX = 6'h00, A_TX = 6'h04, A_CTL = 6'h08;
  localparam logic [5:0] A_BURST = 6'h20, A_XMIT = 6'h24, A_STAT = 6'h28;

  logic en_q, mst_q, cpha_q, cpol_q, csl_q, man_q, lvl_q, busy_q;
  logic [1:0] sel_q;
  logic [CNT_W-1:0] burst_q, xmit_q, rem_q, idx_q;
  logic [3:0] hc_q;
  logic ph_q, mosi_q;
  logic [7:0] tx_sh, rx_sh;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp, tx_cnt, rx_cnt;

  logic wr_ctl, tx_full, tx_empty, rx_full, rx_empty;
  logic start_go, abort, step, byte_end, last, load, ld_cpha, take;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [CNT_W-1:0] fetch_idx;
  logic [7:0] nb, rx_byte;

  assign wr_ctl   = bus_wr && (bus_addr == A_CTL);
  assign tx_cnt   = tx_wp - tx_rp;
  assign rx_cnt   = rx_wp - rx_rp;
  assign tx_full  = (tx_cnt == PW'(DEPTH));
  assign rx_full  = (rx_cnt == PW'(DEPTH));
  assign tx_empty = (tx_cnt == '0);
  assign rx_empty = (rx_cnt == '0);

  assign start_go  = wr_ctl && bus_wdata[10] && bus_wdata[0] && bus_wdata[1] && !busy_q && (burst_q != '0);
  assign abort     = busy_q && wr_ctl && !bus_wdata[0];
  assign step      = busy_q && bit_tick && !abort;
  assign byte_end  = step && (hc_q == 4'hF);
  assign last      = (rem_q == CNT_W'(1));
  assign load      = start_go || (byte_end && !last);
  assign ld_cpha   = start_go ? bus_wdata[2] : cpha_q;
  assign fetch_idx = start_go ? '0 : idx_q;
  assign take      = (fetch_idx < xmit_q) && !tx_empty;
  assign nb        = take ? tx_mem[tx_rp[FIFO_AW-1:0]] : 8'h00;
  assign rx_byte   = cpha_q ? {rx_sh[6:0], miso} : rx_sh;

  assign tx_push = bus_wr && (bus_addr == A_TX) && !tx_full;
  assign tx_pop  = load && take;
  assign rx_push = byte_end && !rx_full;
  assign rx_pop  = bus_rd && (bus_addr == A_RX) && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, mst_q, cpha_q, cpol_q, csl_q, man_q, lvl_q} <= '0;
      sel_q   <= '0;
      burst_q <= '0;
      xmit_q  <= '0;
    end else begin
      if (wr_ctl) begin
        en_q   <= bus_wdata[0];
        mst_q  <= bus_wdata[1];
        cpha_q <= bus_wdata[2];
        cpol_q <= bus_wdata[3];
        csl_q  <= bus_wdata[4];
        sel_q  <= bus_wdata[13:12];
        man_q  <= bus_wdata[16];
        lvl_q  <= bus_wdata[17];
      end
      if (bus_wr && bus_addr == A_BURST) burst_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == A_XMIT)  xmit_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (wr_ctl && bus_wdata[8]) tx_rp <= tx_wp;
      else if (tx_pop) tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (wr_ctl && bus_wdata[9]) rx_rp <= rx_wp;
      else if (rx_pop) rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[FIFO_AW-1:0]] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp[FIFO_AW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rem_q <= '0; idx_q <= '0; hc_q <= '0; ph_q <= 1'b0;
      mosi_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      if (abort) begin
        busy_q <= 1'b0; hc_q <= '0; ph_q <= 1'b0;
      end else if (start_go) begin
        busy_q <= 1'b1; rem_q <= burst_q; hc_q <= '0; ph_q <= 1'b0;
      end else if (step) begin
        hc_q <= hc_q + 1'b1;
        ph_q <= ~ph_q;
        if (!hc_q[0]) begin
          if (!cpha_q) rx_sh <= {rx_sh[6:0], miso};
          else begin mosi_q <= tx_sh[7]; tx_sh <= {tx_sh[6:0], 1'b0}; end
        end else if (cpha_q) begin
          rx_sh <= {rx_sh[6:0], miso};
        end else if (!byte_end) begin
          mosi_q <= tx_sh[7]; tx_sh <= {tx_sh[6:0], 1'b0};
        end
        if (byte_end) begin
          rem_q <= rem_q - 1'b1;
          if (last) busy_q <= 1'b0;
        end
      end
      if (load) begin
        idx_q <= fetch_idx + 1'b1;
        if (ld_cpha) tx_sh <= nb;
        else begin mosi_q <= nb[7]; tx_sh <= {nb[6:0], 1'b0}; end
      end
    end
  end

  assign sck  = cpol_q ^ ph_q;
  assign mosi = mosi_q;

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_line[i] = (sel_q == 2'(i)) ? (man_q ? lvl_q : (busy_q ^ csl_q)) : csl_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RX:    if (!rx_empty) bus_rdata[7:0] = rx_mem[rx_rp[FIFO_AW-1:0]];
      A_CTL: begin
        bus_rdata[0]     = en_q;
        bus_rdata[1]     = mst_q;
        bus_rdata[2]     = cpha_q;
        bus_rdata[3]     = cpol_q;
        bus_rdata[4]     = csl_q;
        bus_rdata[10]    = busy_q;
        bus_rdata[13:12] = sel_q;
        bus_rdata[16]    = man_q;
        bus_rdata[17]    = lvl_q;
      end
      A_BURST: bus_rdata[CNT_W-1:0] = burst_q;
      A_XMIT:  bus_rdata[CNT_W-1:0] = xmit_q;
      A_STAT: begin
        bus_rdata[PW-1:0]   = rx_cnt;
        bus_rdata[16 +: PW] = tx_cnt;
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_fifo_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= PW'(DEPTH)) && (rx_cnt <= PW'(DEPTH)));
  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_ctl && !bus_wdata[0]) |=> !busy_q);
  assert_done_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (rem_q == '0 || !en_q));
  assert_one_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_line ^ {4{csl_q}}));
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sck == cpol_q));
  assert_sck_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_tick && !wr_ctl) |=> $stable(sck));
endmodule

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bit_tick = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, cs_unused;
  logic [3:0] cs_line;
  logic miso_r = 1'b0;
  int checks = 0, errors = 0;

  localparam logic [5:0] A_RX = 6'h00, A_TX = 6'h04, A_CTL = 6'h08;
  localparam logic [5:0] A_BURST = 6'h20, A_XMIT = 6'h24, A_STAT = 6'h28;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_tick(bit_tick), .sck(sck),
    .mosi(mosi), .miso(miso_r), .cs_line(cs_line));

  always #2 clk = ~clk;
  initial forever begin @(negedge clk); bit_tick = ~bit_tick; end

  int s_mode = 0, s_bi = 0, s_bidx = 0, s_rcnt = 0, s_ngot = 0, s_edges = 0;
  logic s_cpol = 1'b0, s_cpha = 1'b0, sck_prev = 1'b0, lead;
  logic [7:0] s_rx = '0;
  logic [7:0] s_got [128];
  logic [7:0] pv;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29 + 90 + s_mode * 7) & 255);
  endfunction
  function automatic logic [7:0] txv(input int k);
    return 8'((k * 13 + 193) & 255);
  endfunction

  always @(negedge clk) begin
    if (rst_n && sck !== sck_prev) begin
      sck_prev = sck;
      s_edges++;
      lead = (sck != s_cpol);
      if (lead != s_cpha) begin
        s_rx = {s_rx[6:0], mosi};
        s_rcnt++;
        if (s_rcnt == 8) begin
          if (s_ngot < 128) s_got[s_ngot] = s_rx;
          s_ngot++; s_rcnt = 0;
        end
        if (s_cpha && s_bi == 8) begin s_bidx++; s_bi = 0; end
      end else if (s_cpha) begin
        pv = pat(s_bidx); miso_r = pv[7 - s_bi]; s_bi++;
      end else begin
        s_bi++;
        if (s_bi == 8) begin s_bidx++; s_bi = 0; end
        pv = pat(s_bidx); miso_r = pv[7 - s_bi];
      end
    end
  end

  task automatic slave_reset(input int mode);
    s_mode = mode; s_cpol = mode[1]; s_cpha = mode[0];
    s_bi = 0; s_bidx = 0; s_rcnt = 0; s_ngot = 0; s_edges = 0;
    sck_prev = sck; pv = pat(0); miso_r = pv[7];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTL, v);
      if (!v[10]) break;
    end
  endtask

  task automatic run_burst(input int mode, input int csl, input int sel, input int n, input int x, input int pre);
    logic [31:0] base, v;
    int used;
    base = 32'h3 | (32'(mode & 1) << 2) | (32'((mode >> 1) & 1) << 3) | (32'(csl) << 4) | (32'(sel) << 12);
    wr(A_CTL, base | 32'h300);
    chk("R5 idle sck", 32'(sck), 32'((mode >> 1) & 1));
    for (int i = 0; i < pre; i++) wr(A_TX, 32'(txv(i)));
    wr(A_BURST, 32'(n)); wr(A_XMIT, 32'(x));
    @(posedge clk); #1 slave_reset(mode);
    wr(A_CTL, base | 32'h400);
    chk("R9 auto cs active", 32'(cs_line), csl ? 32'(4'hF & ~(4'h1 << sel)) : 32'(4'h1 << sel));
    rd(A_CTL, v);
    chk("R4 start reads 1", 32'(v[10]), 32'd1);
    wait_idle();
    chk("R9 auto cs idle", 32'(cs_line), csl ? 32'hF : 32'h0);
    chk("R11 byte count", 32'(s_ngot), 32'(n));
    chk("R11 edge count", 32'(s_edges), 32'(16 * n));
    used = (x < pre) ? x : pre;
    for (int k = 0; k < n; k++)
      chk("R6 mosi byte", 32'(s_got[k]), (k < used) ? 32'(txv(k)) : 32'h0);
    if (used > n) used = n;
    rd(A_STAT, v);
    chk("R2 rx level", 32'(v[6:0]), 32'(n));
    chk("R2 tx level", 32'(v[22:16]), 32'(pre - used));
    for (int k = 0; k < n; k++) begin
      rd(A_RX, v);
      chk("R5 miso byte", v, 32'(pat(k)));
    end
    rd(A_RX, v);
    chk("R7 empty read", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int edges_then;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(A_CTL, v);   chk("R1 ctl", v, 32'h0);
    rd(A_STAT, v);  chk("R1 status", v, 32'h0);
    rd(A_BURST, v); chk("R1 burst", v, 32'h0);
    chk("R1 cs", 32'(cs_line), 32'h0);
    chk("R1 sck", 32'(sck), 32'h0);

    for (int i = 0; i < 65; i++) wr(A_TX, 32'(i));
    rd(A_STAT, v); chk("R2 tx full drop", 32'(v[22:16]), 32'd64);
    wr(A_CTL, 32'h103);
    rd(A_STAT, v); chk("R3 tx flush", 32'(v[22:16]), 32'd0);
    rd(A_CTL, v);  chk("R3 flush bits read 0", 32'(v[9:8]), 32'd0);

    wr(A_BURST, 32'd4);
    wr(A_CTL, 32'h402);
    rd(A_CTL, v); chk("R4 start without enable", 32'(v[10]), 32'd0);
    wr(A_CTL, 32'h401);
    rd(A_CTL, v); chk("R4 start without master", 32'(v[10]), 32'd0);
    chk("R4 no sck activity", 32'(sck), 32'd0);
    wr(A_BURST, 32'd0);
    wr(A_CTL, 32'h403);
    rd(A_CTL, v); chk("R4 zero burst", 32'(v[10]), 32'd0);

    for (int m = 0; m < 4; m++) begin
      run_burst(m, m % 2, m, 1, 1, 1);
      run_burst(m, (m + 1) % 2, 3 - m, 3, 3, 3);
      run_burst(m, 0, m, 4, 2, 2);
      run_burst(m, 1, m, 3, 3, 1);
      run_burst(m, 0, m, 2, 0, 2);
    end

    wr(A_CTL, 32'h303);
    wr(A_BURST, 32'd66); wr(A_XMIT, 32'd0);
    @(posedge clk); #1 slave_reset(0);
    wr(A_CTL, 32'h403);
    wait_idle();
    rd(A_STAT, v); chk("R7 rx full drop", 32'(v[6:0]), 32'd64);
    rd(A_RX, v);   chk("R7 first kept byte", v, 32'(pat(0)));
    wr(A_CTL, 32'h203);
    rd(A_STAT, v); chk("R3 rx flush", 32'(v[6:0]), 32'd0);

    wr(A_BURST, 32'd20);
    @(posedge clk); #1 slave_reset(0);
    wr(A_CTL, 32'h403);
    repeat (100) @(negedge clk);
    wr(A_CTL, 32'h002);
    rd(A_CTL, v); chk("R10 abort clears start", 32'(v[10]), 32'd0);
    chk("R10 sck idle", 32'(sck), 32'd0);
    edges_then = s_edges;
    repeat (200) @(negedge clk);
    chk("R10 no further edges", 32'(s_edges), 32'(edges_then));

    wr(A_CTL, 32'h32003);
    chk("R9 manual high", 32'(cs_line), 32'h4);
    wr(A_CTL, 32'h12003);
    chk("R9 manual low", 32'(cs_line), 32'h0);
    wr(A_CTL, 32'h12013);
    chk("R8 active low manual", 32'(cs_line), 32'hB);
    wr(A_CTL, 32'h03013);
    chk("R8 active low idle sel3", 32'(cs_line), 32'hF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule